// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, from the six destination-address bytes at the head of each frame, whether the frame is kept or dropped. Bytes arrive one per `byte_valid` cycle. The first byte is flagged by `sof`. The filter compares the address against a programmed station address and against the all-ones broadcast address. It also runs a reflected CRC-32 over the six bytes, and the top bits of that CRC index a 64-bin multicast hash table.

One decision is produced per frame. It is a single-cycle `verdict_valid` pulse, with `verdict_accept` giving the result. A receive-enable bit gates everything. A promiscuous bit bypasses all address checks. A hash-enable bit allows the hash table to admit frames that match neither the station address nor broadcast. Payload bytes after the address are ignored, so frame storage, DMA and FCS checking stay outside this block.

Top module: `dst_addr_filter`

## Requirements
- R1: When `cfg_rx_en` is 0, every decided frame has `verdict_accept` = 0, whatever the address and the other configuration bits.
- R2: When `cfg_rx_en` is 1 and `cfg_promisc` is 1, every decided frame is accepted.
- R3: A destination equal to the station address is accepted. `station_addr` holds three 16-bit words; word k sits at bits [16k+15:16k]. Its high byte (bits 15:8) is address byte 2k and its low byte is byte 2k+1, where byte 0 is the first on the wire.
- R4: A destination whose six bytes are all 0xFF is accepted as broadcast. If any byte differs, broadcast does not match.
- R5: The hash index is bits 31:26 of a CRC-32 over the six bytes. The CRC starts at 0xFFFFFFFF, uses polynomial 0xEDB88320, takes each byte least significant bit first, and is not inverted at the end. The hash table is consulted only when `cfg_hash_en` is 1 and neither the station nor the broadcast check matched.
- R6: Index bits 5:4 pick hash word w = `hash_table[16w+15:16w]`, and index bits 3:0 pick the bit within that word. A set bit accepts the frame and a clear bit rejects it.
- R7: With receive enabled and promiscuous off, a frame that matches no check is rejected; this includes a frame that would hit the table while `cfg_hash_en` is 0.
- R8: `verdict_valid` is high for exactly one cycle per frame, in the cycle after the sixth address byte is taken. `verdict_accept` is 0 whenever `verdict_valid` is 0.
- R9: Cycles with `byte_valid` low between address bytes are skipped. Bytes after the sixth are ignored until the next `sof`.
- R10: A byte taken with `sof` high restarts the address collection, even in the middle of a frame's address. A partial address produces no decision.
- R11: The configuration bits are used as they stand in the cycle the sixth byte is taken. Their values during earlier bytes have no effect.
- R12: After reset, `verdict_valid` and `verdict_accept` are 0. `sof` counts only together with `byte_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Marks the byte taken this cycle as the first of a frame |
| byte_valid | input | 1 | A frame byte is present on `byte_data` |
| byte_data | input | 8 | Frame byte |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_promisc | input | 1 | Accept all frames without address checks |
| cfg_hash_en | input | 1 | Allow the multicast hash table to accept |
| station_addr | input | 48 | Station address, three 16-bit words, high byte first |
| hash_table | input | 64 | Multicast hash table, four 16-bit words |
| verdict_valid | output | 1 | One-cycle pulse carrying the frame decision |
| verdict_accept | output | 1 | 1 = keep the frame, valid with `verdict_valid` |

## Verification
The bench builds the filter with its default parameters: 16-bit words, four hash words, and therefore a 64-bin table with a 6-bit index. At that size, the bench can walk sixty-four multicast addresses through the table with a single bin set and then with all bins but one set, so both polarities of the CRC indexing are exercised across many bins. The bench also sweeps all eight combinations of the three configuration bits, and it flips each station byte in turn to check the local comparison at every byte position.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int CRC_W      = 32;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        logic             active;   // collecting address bytes
        logic [CNT_W-1:0] cnt;      // bytes taken so far
        logic [CRC_W-1:0] crc;      // running hash CRC
        logic             loc_ok;   // all bytes so far equal the station address
        logic             bc_ok;    // all bytes so far are 0xFF
        logic             vld;      // decision pulse
        logic             acc;      // decision result
    } filt_state_t;

    // Priority: enable gate, promiscuous, exact/broadcast, hash.
    function automatic logic filt_decide(input logic rx_en, input logic promisc,
                                         input logic hash_en, input logic addr_hit,
                                         input logic hash_hit);
        logic r;
        if (!rx_en)        r = 1'b0;
        else if (promisc)  r = 1'b1;
        else if (addr_hit) r = 1'b1;
        else if (hash_en)  r = hash_hit;
        else               r = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/dfilt_crc_byte.sv
module dfilt_crc_byte #(
    parameter int                 CRC_W  = 32,
    parameter int                 DATA_W = 8,
    parameter logic [CRC_W-1:0]   POLY   = 32'hEDB88320
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    // One reflected shift stage per data bit, least significant first.
    logic [DATA_W:0][CRC_W-1:0] chain;

    assign chain[0] = crc_in;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic fb;
        assign fb           = chain[b][0] ^ data_in[b];
        assign chain[b + 1] = (chain[b] >> 1) ^ (fb ? POLY : '0);
    end

    assign crc_out = chain[DATA_W];

endmodule

// File: rtl/dfilt_station_cmp.sv
module dfilt_station_cmp #(
    parameter int N_BYTES = 6,
    parameter int WORD_W  = 16,
    parameter int IDX_W   = 3
) (
    input  logic [N_BYTES*8-1:0] station_words,
    input  logic [IDX_W-1:0]     byte_idx,
    input  logic [7:0]           rx_byte,
    output logic                 byte_match
);
    localparam int BPW = WORD_W / 8;

    logic [N_BYTES-1:0] hit_vec;

    // Byte k lives in word k/BPW, high byte first within the word.
    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        localparam int OFS = (k / BPW) * WORD_W + WORD_W - 8 * ((k % BPW) + 1);
        logic [7:0] stn_byte;
        assign stn_byte   = station_words[OFS +: 8];
        assign hit_vec[k] = (byte_idx == IDX_W'(k)) && (rx_byte == stn_byte);
    end

    assign byte_match = |hit_vec;

endmodule

// File: rtl/dfilt_hash_lookup.sv
module dfilt_hash_lookup #(
    parameter int WORD_W    = 16,
    parameter int TAB_WORDS = 4
) (
    input  logic [$clog2(TAB_WORDS*WORD_W)-1:0] index_in,
    input  logic [TAB_WORDS*WORD_W-1:0]         tab_bits,
    output logic                                hit
);
    localparam int IDX_W = $clog2(TAB_WORDS * WORD_W);
    localparam int BIT_W = $clog2(WORD_W);
    localparam int SEL_W = IDX_W - BIT_W;

    logic [WORD_W-1:0] words [TAB_WORDS];
    logic [SEL_W-1:0]  word_sel;
    logic [BIT_W-1:0]  bit_sel;

    for (genvar w = 0; w < TAB_WORDS; w++) begin : g_word
        assign words[w] = tab_bits[w*WORD_W +: WORD_W];
    end

    assign word_sel = index_in[IDX_W-1 -: SEL_W];
    assign bit_sel  = index_in[BIT_W-1:0];
    assign hit      = words[word_sel][bit_sel];

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import dfilt_pkg::*;
#(
    parameter int               WORD_W    = 16,
    parameter int               TAB_WORDS = 4,
    parameter logic [31:0]      CRC_POLY  = 32'hEDB88320,
    parameter logic [31:0]      CRC_INIT  = 32'hFFFFFFFF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sof,
    input  logic                          byte_valid,
    input  logic [7:0]                    byte_data,
    input  logic                          cfg_rx_en,
    input  logic                          cfg_promisc,
    input  logic                          cfg_hash_en,
    input  logic [ADDR_BYTES*8-1:0]       station_addr,
    input  logic [TAB_WORDS*WORD_W-1:0]   hash_table,
    output logic                          verdict_valid,
    output logic                          verdict_accept
);
    localparam int IDX_W = $clog2(TAB_WORDS * WORD_W);

    filt_state_t q, d;

    logic             take;
    logic [CNT_W-1:0] pos;
    logic [CRC_W-1:0] crc_base;
    logic [CRC_W-1:0] crc_new;
    logic             loc_base;
    logic             bc_base;
    logic             byte_hit;
    logic             hash_hit;
    logic             last_byte;

    // A byte counts when it starts a frame or continues an open address.
    assign take      = byte_valid && (sof || q.active);
    assign pos       = sof ? '0 : q.cnt;
    assign crc_base  = sof ? CRC_INIT : q.crc;
    assign loc_base  = sof ? 1'b1 : q.loc_ok;
    assign bc_base   = sof ? 1'b1 : q.bc_ok;
    assign last_byte = (pos == CNT_W'(ADDR_BYTES - 1));

    dfilt_crc_byte #(
        .CRC_W  (CRC_W),
        .DATA_W (8),
        .POLY   (CRC_POLY)
    ) u_crc (
        .crc_in  (crc_base),
        .data_in (byte_data),
        .crc_out (crc_new)
    );

    dfilt_station_cmp #(
        .N_BYTES (ADDR_BYTES),
        .WORD_W  (WORD_W),
        .IDX_W   (CNT_W)
    ) u_stn (
        .station_words (station_addr),
        .byte_idx      (pos),
        .rx_byte       (byte_data),
        .byte_match    (byte_hit)
    );

    dfilt_hash_lookup #(
        .WORD_W    (WORD_W),
        .TAB_WORDS (TAB_WORDS)
    ) u_hash (
        .index_in (crc_new[CRC_W-1 -: IDX_W]),
        .tab_bits (hash_table),
        .hit      (hash_hit)
    );

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.acc = 1'b0;
        if (take) begin
            d.crc    = crc_new;
            d.loc_ok = loc_base && byte_hit;
            d.bc_ok  = bc_base && (&byte_data);
            d.cnt    = pos + CNT_W'(1);
            d.active = !last_byte;
            if (last_byte) begin
                d.vld = 1'b1;
                d.acc = filt_decide(cfg_rx_en, cfg_promisc, cfg_hash_en,
                                    d.loc_ok || d.bc_ok, hash_hit);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign verdict_valid  = q.vld;
    assign verdict_accept = q.acc;

endmodule

// File: rtl/dfilt_checker.sv
module dfilt_checker (
    input logic clk,
    input logic rst_n,
    input logic byte_valid,
    input logic cfg_rx_en,
    input logic cfg_promisc,
    input logic verdict_valid,
    input logic verdict_accept
);
    AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid); // R8

    AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_accept |-> verdict_valid); // R8

    AST_VALID_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> $past(byte_valid)); // R9

    AST_DISABLED_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && !$past(cfg_rx_en)) |-> !verdict_accept); // R1

    AST_PROMISC_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && $past(cfg_rx_en && cfg_promisc)) |-> verdict_accept); // R2

endmodule

bind dst_addr_filter dfilt_checker u_dfilt_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .byte_valid     (byte_valid),
    .cfg_rx_en      (cfg_rx_en),
    .cfg_promisc    (cfg_promisc),
    .verdict_valid  (verdict_valid),
    .verdict_accept (verdict_accept)
);

// File: tb/tb_dst_addr_filter.sv
`timescale 1ns/1ps
module tb_dst_addr_filter;

    localparam logic [31:0] POLY = 32'hEDB88320;
    localparam logic [47:0] STN  = 48'h02_11_22_33_44_55;
    localparam logic [47:0] BCST = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] OTHR = 48'h0A_0B_0C_0D_0E_0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        cfg_rx_en = 1'b1;
    logic        cfg_promisc = 1'b0;
    logic        cfg_hash_en = 1'b1;
    logic [47:0] station_addr;
    logic [63:0] hash_table = '0;
    logic        verdict_valid;
    logic        verdict_accept;

    int n_chk = 0;
    int n_fail = 0;
    int vcount = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Word k = {byte 2k, byte 2k+1}, word 0 in the low 16 bits.
    assign station_addr = {STN[15:0], STN[31:16], STN[47:32]};

    dst_addr_filter dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sof            (sof),
        .byte_valid     (byte_valid),
        .byte_data      (byte_data),
        .cfg_rx_en      (cfg_rx_en),
        .cfg_promisc    (cfg_promisc),
        .cfg_hash_en    (cfg_hash_en),
        .station_addr   (station_addr),
        .hash_table     (hash_table),
        .verdict_valid  (verdict_valid),
        .verdict_accept (verdict_accept)
    );

    always @(negedge clk) if (verdict_valid) vcount++;

    function automatic logic [5:0] ref_index(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 6; i++) begin
            c = c ^ {24'h0, a[47-8*i -: 8]};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
        end
        return c[31:26];
    endfunction

    task automatic check(input string tag, input logic got, input logic exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
        end
    endtask

    task automatic drive_byte(input logic [7:0] b, input logic s);
        byte_data  = b;
        sof        = s;
        byte_valid = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
        sof        = 1'b0;
    endtask

    task automatic send_addr(input logic [47:0] a, input int gap, output logic v, output logic acc);
        for (int i = 0; i < 6; i++) begin
            drive_byte(a[47-8*i -: 8], i == 0);
            if (i == 5) begin
                v   = verdict_valid;
                acc = verdict_accept;
            end
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic frame_check(input logic [47:0] a, input logic exp, input string tag, input string what);
        logic v, acc;
        send_addr(a, 0, v, acc);
        check(tag, v, 1'b1, {what, " valid"});
        check(tag, acc, exp, what);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic v, acc;
        int v0;
        logic [47:0] a;
        logic [5:0] idx;

        repeat (3) @(negedge clk);
        // R12: reset state, sof without byte_valid does nothing
        check("R12", verdict_valid, 1'b0, "valid in reset");
        check("R12", verdict_accept, 1'b0, "accept in reset");
        rst_n = 1'b1;
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        repeat (6) @(negedge clk);
        check("R12", verdict_valid, 1'b0, "lone sof");

        // R3: station match, and each byte flipped in turn
        frame_check(STN, 1'b1, "R3", "station match");
        for (int k = 0; k < 6; k++) begin
            a = STN ^ (48'h01 << (8 * k));
            frame_check(a, 1'b0, "R3", "station byte mismatch");
        end

        // R4: broadcast and near-broadcast
        frame_check(BCST, 1'b1, "R4", "broadcast");
        frame_check(48'hFF_FF_FF_FF_FF_FE, 1'b0, "R4", "near broadcast");
        frame_check(48'h7F_FF_FF_FF_FF_FF, 1'b0, "R4", "near broadcast first");

        // R1 R2 R7: configuration sweep, table all ones, address unmatched
        hash_table = '1;
        for (int c = 0; c < 8; c++) begin
            cfg_rx_en   = c[0];
            cfg_promisc = c[1];
            cfg_hash_en = c[2];
            frame_check(OTHR, c[0] && (c[1] || c[2]), "R1_R2_R7", "config sweep");
        end
        cfg_rx_en = 1'b0; cfg_promisc = 1'b1;
        frame_check(STN, 1'b0, "R1", "disabled station");
        frame_check(BCST, 1'b0, "R1", "disabled broadcast");
        cfg_rx_en = 1'b1; cfg_promisc = 1'b0; cfg_hash_en = 1'b1;

        // R5 R6: hash bins, single bin set then all but one
        for (int k = 0; k < 64; k++) begin
            a   = {8'h01, 8'h00, 8'h5E, 8'h7F, 8'(k), 8'(k * 7 + 3)};
            idx = ref_index(a);
            hash_table = 64'h1 << idx;
            frame_check(a, 1'b1, "R5_R6", "hash bin set");
            hash_table = ~(64'h1 << idx);
            frame_check(a, 1'b0, "R5_R6", "hash bin clear");
        end
        // R7: hit in table but hash disabled
        a = {8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01};
        hash_table = 64'h1 << ref_index(a);
        cfg_hash_en = 1'b0;
        frame_check(a, 1'b0, "R7", "hash disabled");
        cfg_hash_en = 1'b1;
        hash_table = '0;

        // R9: gaps between bytes
        send_addr(STN, 2, v, acc);
        check("R9", v, 1'b1, "gapped valid");
        check("R9", acc, 1'b1, "gapped station");

        // R8 R9: one pulse, trailing bytes ignored
        #1;
        v0 = vcount;
        send_addr(STN, 0, v, acc);
        for (int i = 0; i < 7; i++) drive_byte(8'hFF, 1'b0);
        repeat (3) @(negedge clk);
        #1;
        check("R8", (vcount - v0) == 1, 1'b1, "single pulse per frame");
        check("R8", verdict_accept, 1'b0, "accept idle low");

        // R10: restart mid-address
        v0 = vcount;
        drive_byte(8'h0A, 1'b1);
        drive_byte(8'h0B, 1'b0);
        drive_byte(8'h0C, 1'b0);
        send_addr(STN, 0, v, acc);
        repeat (2) @(negedge clk);
        #1;
        check("R10", acc, 1'b1, "restart station");
        check("R10", (vcount - v0) == 1, 1'b1, "no decision for partial");

        // R11: configuration sampled with the sixth byte
        cfg_rx_en = 1'b0;
        for (int i = 0; i < 5; i++) drive_byte(STN[47-8*i -: 8], i == 0);
        cfg_rx_en = 1'b1;
        drive_byte(STN[7:0], 1'b0);
        check("R11", verdict_accept, 1'b1, "enable at last byte");
        @(negedge clk);
        for (int i = 0; i < 5; i++) drive_byte(STN[47-8*i -: 8], i == 0);
        cfg_rx_en = 1'b0;
        drive_byte(STN[7:0], 1'b0);
        check("R11", verdict_valid, 1'b1, "disable at last byte valid");
        check("R11", verdict_accept, 1'b0, "disable at last byte");
        cfg_rx_en = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule